// File: doc/BRIEF.md
# Sync-Aided Spread-Spectrum Despreading Receiver

The block recovers the data of one selected channel from a 2-bit multi-level baseband stream. Three channels are spread by distinct length-127 pseudo-noise codes and summed ahead of the block. A sync input marks the first sample of each code period. On that cycle the block takes in the channel select and restarts a local code generator for the chosen channel. It then correlates the next 127 samples against that code in a signed accumulator.

Each received sample is first centered: a sample value s becomes 2*s-3, which gives one of -3, -1, +1 or +3. The centered value is then added when the local code bit is 1 and subtracted when it is 0. After the last sample of the period, the sign of the sum decides the data bit. A positive sum gives 0 and a negative sum gives 1. A one-cycle valid pulse marks the decision, and the data output keeps its value until the next decision.

Top module: `cdma_despread_rx`

## Requirements
- R1: While reset (active high) is asserted, and after it is released, validOut is 0 and dataOut is 0 until the first decision.
- R2: Each received sample s (0..3) contributes +(2s-3) to the correlation when the local code bit is 1 and -(2s-3) when it is 0.
- R3: If syncIn is sampled high at clock edge k, the samples taken at edges k through k+126 form the period. validOut is then high for exactly one cycle, from edge k+126 to edge k+127.
- R4: At the decision, dataOut becomes 1 when the 127-sample correlation is negative and 0 when it is positive.
- R5: chanSel is sampled only on the sync edge, so later changes within the period have no effect. The values 01, 10 and 11 pick codes with tap k = 1, 3 and 4. Each code follows c[0..6] = 1 and c[n+7] = c[n] XOR c[n+k], and sample i of the period is matched with c[i].
- R6: A period started with chanSel = 00 produces no valid pulse and leaves dataOut unchanged.
- R7: dataOut changes only in the cycle in which validOut is high, and otherwise holds the last decided bit.
- R8: A sync that arrives before a period is complete discards the partial sum and restarts the code, and the aborted period gives no valid pulse. This includes a sync that arrives exactly on the 127th sample.
- R9: A sync on the cycle right after the 127th sample starts a new period without losing the pending decision. Once a period ends and no sync follows, the block stays idle and produces no further valid pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| rxSample | input | 2 | Received multi-level sample |
| syncIn | input | 1 | Marks the first sample of a code period |
| chanSel | input | 2 | Channel select; 00 suppresses output |
| dataOut | output | 1 | Decided data bit, held between decisions |
| validOut | output | 1 | One-cycle pulse when dataOut is updated |

## Verification
Two events can land on the same clock edge: the restart of the correlation by a sync pulse, and the decision for the period that is ending. In the back-to-back case, the sync arrives on the cycle right after the 127th sample. The bench then checks that the pending valid pulse and bit appear, and that the new period's result depends only on its own samples. In the second case, the sync lands exactly on the 127th sample. The bench checks that the restart wins, that no valid pulse appears, and that the following full period decodes correctly.

// File: rtl/cdma_rx_pkg.sv
package cdma_rx_pkg;

  typedef struct packed {
    logic load;    // sync seen: restart code and sum with this sample
    logic step;    // accumulate this sample within an open period
    logic decide;  // this sample closes the period and a bit is produced
  } rxStrobe_t;

  // feedback tap of the code recurrence for channel index (0-based)
  function automatic int pnTap(input int idx);
    case (idx)
      0:       return 1;
      1:       return 3;
      default: return 4;
    endcase
  endfunction

endpackage

// File: rtl/cdma_rx_ctrl.sv
module cdma_rx_ctrl
  import cdma_rx_pkg::*;
#(
  parameter int LEN  = 127,
  parameter int CH_W = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            syncIn,
  input  logic [CH_W-1:0] chanSel,
  output rxStrobe_t       strobe,
  output logic [CH_W-1:0] chanLatched,
  output logic            validOut
);

  localparam int CNT_W = $clog2(LEN);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(LEN - 1);

  logic             active;
  logic [CNT_W-1:0] sampleCnt;

  always_comb begin
    strobe.load   = syncIn;
    strobe.step   = !syncIn && active;
    strobe.decide = strobe.step && (sampleCnt == LAST) && (chanLatched != '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active      <= 1'b0;
      sampleCnt   <= '0;
      chanLatched <= '0;
      validOut    <= 1'b0;
    end else begin
      validOut <= strobe.decide;
      if (strobe.load) begin
        active      <= 1'b1;
        sampleCnt   <= CNT_W'(1);
        chanLatched <= chanSel;
      end else if (strobe.step) begin
        if (sampleCnt == LAST) begin
          active    <= 1'b0;
          sampleCnt <= '0;
        end else begin
          sampleCnt <= sampleCnt + CNT_W'(1);
        end
      end
    end
  end

endmodule

// File: rtl/cdma_rx_dpath.sv
module cdma_rx_dpath
  import cdma_rx_pkg::*;
#(
  parameter int LEN  = 127,
  parameter int SW   = 2,
  parameter int NCH  = 3,
  parameter int CH_W = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  rxStrobe_t       strobe,
  input  logic [CH_W-1:0] chanLatched,
  input  logic [SW-1:0]   rxSample,
  output logic            dataOut
);

  localparam int DEG    = $clog2(LEN + 1);
  localparam int MAXLVL = (2 ** SW) - 1;
  localparam int ACC_W  = $clog2(LEN * MAXLVL + 1) + 1;
  localparam logic [DEG-1:0] ONES = '1;

  logic [NCH-1:0] codeBits;
  logic           codeBit;

  genvar g;
  generate
    for (g = 0; g < NCH; g++) begin : gen_pn
      localparam int TAP = pnTap(g);
      logic [DEG-1:0] pnState;
      always_ff @(posedge clk) begin
        if (rst) begin
          pnState <= ONES;
        end else if (strobe.load) begin
          pnState <= {ONES[0] ^ ONES[TAP], ONES[DEG-1:1]};
        end else if (strobe.step) begin
          pnState <= {pnState[0] ^ pnState[TAP], pnState[DEG-1:1]};
        end
      end
      assign codeBits[g] = strobe.load ? ONES[0] : pnState[0];
    end
  endgenerate

  always_comb begin
    codeBit = codeBits[0];
    for (int i = 0; i < NCH; i++) begin
      if (int'(chanLatched) == i + 1) codeBit = codeBits[i];
    end
  end

  logic signed [ACC_W-1:0] acc;
  logic signed [ACC_W-1:0] centered;
  logic signed [ACC_W-1:0] term;
  logic signed [ACC_W-1:0] base;
  logic signed [ACC_W-1:0] nextSum;

  always_comb begin
    centered = $signed(ACC_W'({rxSample, 1'b0})) - $signed(ACC_W'(MAXLVL));
    term     = codeBit ? centered : -centered;
    base     = strobe.load ? '0 : acc;
    nextSum  = base + term;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc     <= '0;
      dataOut <= 1'b0;
    end else begin
      if (strobe.load || strobe.step) acc <= nextSum;
      if (strobe.decide) dataOut <= nextSum[ACC_W-1];
    end
  end

endmodule

// File: rtl/cdma_despread_rx.sv
module cdma_despread_rx
  import cdma_rx_pkg::*;
#(
  parameter int LEN  = 127,
  parameter int SW   = 2,
  parameter int NCH  = 3,
  parameter int CH_W = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [SW-1:0]   rxSample,
  input  logic            syncIn,
  input  logic [CH_W-1:0] chanSel,
  output logic            dataOut,
  output logic            validOut
);

  rxStrobe_t       strobe;
  logic [CH_W-1:0] chanLatched;

  cdma_rx_ctrl #(.LEN(LEN), .CH_W(CH_W)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .syncIn     (syncIn),
    .chanSel    (chanSel),
    .strobe     (strobe),
    .chanLatched(chanLatched),
    .validOut   (validOut)
  );

  cdma_rx_dpath #(.LEN(LEN), .SW(SW), .NCH(NCH), .CH_W(CH_W)) u_dpath (
    .clk        (clk),
    .rst        (rst),
    .strobe     (strobe),
    .chanLatched(chanLatched),
    .rxSample   (rxSample),
    .dataOut    (dataOut)
  );

endmodule

// File: rtl/cdma_despread_rx_chk.sv
module cdma_despread_rx_chk #(
  parameter int LEN  = 127,
  parameter int CH_W = 2
) (
  input logic            clk,
  input logic            rst,
  input logic            syncIn,
  input logic [CH_W-1:0] chanSel,
  input logic            dataOut,
  input logic            validOut
);

  localparam int SC_W = $clog2(LEN + 2);
  localparam logic [SC_W-1:0] SAT = SC_W'(LEN + 1);

  logic [SC_W-1:0] sinceSync;
  logic [CH_W-1:0] chanAtSync;

  always_ff @(posedge clk) begin
    if (rst) begin
      sinceSync  <= '0;
      chanAtSync <= '0;
    end else if (syncIn) begin
      sinceSync  <= SC_W'(1);
      chanAtSync <= chanSel;
    end else if (sinceSync != '0 && sinceSync != SAT) begin
      sinceSync <= sinceSync + SC_W'(1);
    end
  end

  AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    validOut |=> !validOut);  // R3

  AST_VALID_AT_PERIOD_END: assert property (@(posedge clk) disable iff (rst)
    validOut |-> (sinceSync == SC_W'(LEN)));  // R3

  AST_NO_VALID_CH_NONE: assert property (@(posedge clk) disable iff (rst)
    validOut |-> (chanAtSync != '0));  // R6

  AST_DOUT_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !validOut |-> $stable(dataOut));  // R7

  AST_SYNC_ABORTS: assert property (@(posedge clk) disable iff (rst)
    syncIn |=> !validOut);  // R8

endmodule

bind cdma_despread_rx cdma_despread_rx_chk #(.LEN(LEN), .CH_W(CH_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .syncIn  (syncIn),
  .chanSel (chanSel),
  .dataOut (dataOut),
  .validOut(validOut)
);

// File: tb/cdma_despread_rx_tb.sv
`timescale 1ns/1ps
module cdma_despread_rx_tb;

  localparam int LEN = 127;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] rxSample = '0;
  logic       syncIn = 1'b0;
  logic [1:0] chanSel = '0;
  logic       dataOut;
  logic       validOut;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  logic [1:0] smp [LEN];

  always #10 clk = ~clk;  // 50 MHz

  cdma_despread_rx u_dut (
    .clk(clk), .rst(rst), .rxSample(rxSample), .syncIn(syncIn),
    .chanSel(chanSel), .dataOut(dataOut), .validOut(validOut)
  );

  task automatic check(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp);
    end
  endtask

  // code defined by c[0..6]=1, c[n+7]=c[n]^c[n+k]
  function automatic logic [LEN-1:0] buildCode(input int ch);
    logic [LEN-1:0] c;
    int k;
    k = (ch == 1) ? 1 : (ch == 2) ? 3 : 4;
    for (int i = 0; i < LEN; i++) begin
      if (i < 7) c[i] = 1'b1;
      else c[i] = c[i-7] ^ c[i-7+k];
    end
    return c;
  endfunction

  function automatic int innerProd(input int ch);
    logic [LEN-1:0] c;
    int sum;
    c = buildCode(ch);
    sum = 0;
    for (int i = 0; i < LEN; i++) begin
      if (c[i]) sum += 2 * int'(smp[i]) - 3;
      else      sum -= 2 * int'(smp[i]) - 3;
    end
    return sum;
  endfunction

  task automatic fillConst(input logic [1:0] v);
    for (int i = 0; i < LEN; i++) smp[i] = v;
  endtask

  task automatic fillRandom();
    for (int i = 0; i < LEN; i++) smp[i] = 2'($urandom_range(0, 3));
  endtask

  // three-channel spread mixture with random data bits
  task automatic fillMix();
    logic [LEN-1:0] c1, c2, c3;
    logic d1, d2, d3;
    c1 = buildCode(1); c2 = buildCode(2); c3 = buildCode(3);
    d1 = 1'($urandom); d2 = 1'($urandom); d3 = 1'($urandom);
    for (int i = 0; i < LEN; i++)
      smp[i] = 2'(int'(c1[i] ^ d1) + int'(c2[i] ^ d2) + int'(c3[i] ^ d3));
  endtask

  // called right after a negedge; returns right after the negedge following the last sample
  task automatic drivePeriod(input int ch, input int nSamp, output bit early);
    early = 1'b0;
    for (int n = 0; n < nSamp; n++) begin
      syncIn   = (n == 0);
      chanSel  = (n == 0) ? 2'(ch) : 2'($urandom_range(0, 3));
      rxSample = smp[n];
      @(negedge clk);
      if (n < nSamp - 1 && validOut) early = 1'b1;
    end
    syncIn = 1'b0;
  endtask

  task automatic idle(input int cycles, output bit seen);
    seen = 1'b0;
    for (int n = 0; n < cycles; n++) begin
      syncIn = 1'b0;
      rxSample = 2'($urandom_range(0, 3));
      @(negedge clk);
      if (validOut) seen = 1'b1;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL R3 watchdog actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    bit early, seen;
    logic expBit, held;
    int ip, ch;
    void'($urandom(32'd12345));

    repeat (4) @(negedge clk);
    check("R1", "valid in reset", validOut, 1'b0);
    check("R1", "dout in reset", dataOut, 1'b0);
    rst = 1'b0;
    @(negedge clk);
    check("R1", "valid after reset", validOut, 1'b0);
    check("R1", "dout after reset", dataOut, 1'b0);

    // all-high samples on channel 1: sum is +3 -> 0
    fillConst(2'd3);
    ip = innerProd(1);
    drivePeriod(1, LEN, early);
    check("R3", "no early valid", early, 1'b0);
    check("R3", "valid after 127th sample", validOut, 1'b1);
    check("R2", "all-3 samples decode", dataOut, 1'(ip < 0));

    // back-to-back: sync right after the 127th sample, all-zero samples give -3 -> 1
    fillConst(2'd0);
    ip = innerProd(1);
    drivePeriod(1, LEN, early);
    check("R9", "no stray valid in back-to-back period", early, 1'b0);
    check("R9", "back-to-back valid", validOut, 1'b1);
    check("R4", "negative sum gives 1", dataOut, 1'(ip < 0));
    held = dataOut;

    // idle without sync: no valid, bit held
    idle(15, seen);
    check("R9", "no valid while idle", seen, 1'b0);
    check("R7", "dout held while idle", dataOut, held);

    // channel 00 with samples that would flip the bit
    fillConst(2'd3);
    drivePeriod(0, LEN, early);
    check("R6", "no valid during ch00 period", early, 1'b0);
    check("R6", "no valid at ch00 end", validOut, 1'b0);
    check("R6", "dout unchanged by ch00", dataOut, held);
    idle(3, seen);
    check("R6", "no late valid for ch00", seen, 1'b0);

    // abort after 50 samples, then a full period on channel 2
    fillConst(2'd0);
    drivePeriod(2, 50, early);
    check("R8", "no valid in aborted period", early | validOut, 1'b0);
    fillRandom();
    ip = innerProd(2);
    drivePeriod(2, LEN, early);
    check("R8", "no stray valid after restart", early, 1'b0);
    check("R8", "valid after restarted period", validOut, 1'b1);
    check("R8", "restart discards partial sum", dataOut, 1'(ip < 0));

    // sync lands exactly on the 127th sample
    fillConst(ip < 0 ? 2'd3 : 2'd0);
    drivePeriod(3, LEN - 1, early);
    check("R8", "no valid before 127th-sample sync", early | validOut, 1'b0);
    fillRandom();
    ip = innerProd(3);
    drivePeriod(3, LEN, early);
    check("R8", "restart at 127th sample suppresses valid", early, 1'b0);
    check("R8", "period after late restart valid", validOut, 1'b1);
    check("R5", "channel 3 decode", dataOut, 1'(ip < 0));

    // each channel with a spread mixture
    for (int c = 1; c <= 3; c++) begin
      idle(2, seen);
      fillMix();
      ip = innerProd(c);
      drivePeriod(c, LEN, early);
      check("R5", "mixture decode valid", validOut & ~early, 1'b1);
      check("R5", "mixture decode per channel", dataOut, 1'(ip < 0));
    end

    // random periods, random gaps, chanSel churn after sync
    for (int p = 0; p < 20; p++) begin
      idle($urandom_range(0, 3), seen);
      check("R9", "no valid in gap", seen, 1'b0);
      ch = $urandom_range(1, 3);
      if ($urandom_range(0, 1) == 1) fillRandom(); else fillMix();
      ip = innerProd(ch);
      expBit = 1'(ip < 0);
      drivePeriod(ch, LEN, early);
      check("R3", "random period valid timing", validOut & ~early, 1'b1);
      check("R4", "random period decision", dataOut, expBit);
      held = dataOut;
      @(negedge clk);
      check("R7", "valid drops after one cycle", validOut, 1'b0);
      check("R7", "dout holds after decision", dataOut, held);
    end

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule